// File: doc/BRIEF.md
# Peripheral Clock Gate with Timed Reset Sequencing

This block controls one peripheral clock. An enable request starts the clock, and a disable request stops it. For a peripheral that has a reset line tied to its gate, enabling follows a fixed timed sequence. The peripheral is first held in reset. After a short wait the clock starts. After a much longer wait the reset is released. A gate with no reset line changes its clock-control bit at once.

Both waits are counted in pulses of a slow reference tick, so their lengths are parameters set for the tick rate in use. Two parameters describe the gate: its position in the control word and the position of its reset bit. A negative reset position marks a gate with no reset. Position 14 selects the gate whose control bit has inverted polarity. The block also produces the gated clock itself, through a latch-based glitch-free cell.

Top module: `periph_clk_gate`

## Requirements
- R1: Reset state: the clock is stopped, so `ctrlBit` = 1 for a normal gate and 0 for the inverted gate. `periphRst`, `busy`, `clkOn` and `gatedClk` are all 0.
- R2: For a normal gate (`GATE_POS` != 14), `ctrlBit` is a stop bit: 1 means stopped and 0 means running. `clkOn` is its inverse.
- R3: For the gate at `GATE_POS` = 14, `ctrlBit` is 1 when the clock runs and 0 when it is stopped. `clkOn` equals `ctrlBit`.
- R4: On a gate with a reset (`RST_POS` >= 0), an accepted enable sets `periphRst` = 1 and `busy` = 1 in the next cycle, while the clock stays stopped.
- R5: In that sequence, the clock starts in the cycle after the clock edge that samples the `PRE_TICKS`-th `refTick`, counted from the cycle after acceptance. A tick in the acceptance cycle does not count.
- R6: After the clock starts, the cycle after the edge that samples the `POST_TICKS`-th further `refTick` has `periphRst` = 0 and `busy` = 0. `periphRst` is never high while `busy` is low.
- R7: On a gate with no reset (`RST_POS` < 0), an enable starts the clock in the next cycle. `busy` and `periphRst` stay 0 at all times.
- R8: A disable request accepted while idle stops the clock in the next cycle. It leaves `periphRst` unchanged and does not raise `busy`.
- R9: While `busy` is 1, enable and disable requests are ignored. The sequence runs to its end unchanged, and no request is queued.
- R10: If enable and disable are requested in the same idle cycle, enable wins.
- R11: `gatedClk` is low whenever `clk` is low. During the high phase of a cycle it equals the `clkOn` value that held before that cycle's rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; also the clock that is gated |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | One-cycle pulse of the slow timing reference |
| enReq | input | 1 | Request to enable the peripheral clock |
| disReq | input | 1 | Request to disable the peripheral clock |
| ctrlBit | output | 1 | Clock-control bit in the gate's own polarity |
| periphRst | output | 1 | Peripheral reset, active high |
| busy | output | 1 | High while an enable sequence is in progress |
| clkOn | output | 1 | Enabled status of the clock |
| gatedClk | output | 1 | Gated copy of `clk` |

## Verification
Every control output is registered. A request sampled at a rising edge therefore shows at the ports one cycle later, and the waits end one cycle after the edge that samples their last tick. The bench keeps a behavioural model of three gates (with reset, without reset, and inverted), updates it at each rising edge from the same inputs, and compares the registered outputs mid-way through the low phase. The gated clock is checked twice per cycle: shortly after the rising edge, against the model's status from before that edge, and in the low phase, where it must be 0. Inputs change just after the falling edge, so every result is sampled away from the edges.

// File: rtl/gate_seq_pkg.sv
`timescale 1ns/1ps
package gate_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rstSet;
    logic rstClr;
    logic clkRun;
    logic clkStop;
    logic cntClr;
  } seqStrobe_t;

endpackage

// File: rtl/gate_glitchfree_cell.sv
`timescale 1ns/1ps
module gate_glitchfree_cell (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic enLat;

  // enable captured only during the low phase of clk
  always_latch begin
    if (!clk) enLat = en;
  end

  assign gclk = clk & enLat;
endmodule

// File: rtl/gate_seq_ctrl.sv
`timescale 1ns/1ps
module gate_seq_ctrl
  import gate_seq_pkg::*;
#(
  parameter bit HAS_RST = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enReq,
  input  logic       disReq,
  input  logic       preDone,
  input  logic       postDone,
  output seqStrobe_t strobe,
  output logic       busy
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        strobe.cntClr = 1'b1;
        if (enReq) begin
          // enable has priority over a simultaneous disable
          if (HAS_RST) begin
            strobe.rstSet = 1'b1;
            nextState     = ST_PRE;
          end else begin
            strobe.clkRun = 1'b1;
          end
        end else if (disReq) begin
          strobe.clkStop = 1'b1;
        end
      end
      ST_PRE: begin
        if (preDone) begin
          strobe.clkRun = 1'b1;
          strobe.cntClr = 1'b1;
          nextState     = ST_POST;
        end
      end
      ST_POST: begin
        if (postDone) begin
          strobe.rstClr = 1'b1;
          strobe.cntClr = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/gate_seq_dp.sv
`timescale 1ns/1ps
module gate_seq_dp
  import gate_seq_pkg::*;
#(
  parameter int unsigned PRE_TICKS  = 100,
  parameter int unsigned POST_TICKS = 10000,
  parameter bit          RUN_HIGH   = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  seqStrobe_t strobe,
  output logic       preDone,
  output logic       postDone,
  output logic       ctrlBit,
  output logic       periphRst,
  output logic       running
);
  localparam int unsigned MAX_TICKS = (PRE_TICKS > POST_TICKS) ? PRE_TICKS : POST_TICKS;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_TICKS - 1);
  localparam logic [CNT_W-1:0] POST_LAST = CNT_W'(POST_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tickCnt <= '0;
    else if (strobe.cntClr) tickCnt <= '0;
    else if (refTick)      tickCnt <= tickCnt + 1'b1;
  end

  assign preDone  = refTick && (tickCnt == PRE_LAST);
  assign postDone = refTick && (tickCnt == POST_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               running <= 1'b0;
    else if (strobe.clkRun)  running <= 1'b1;
    else if (strobe.clkStop) running <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              periphRst <= 1'b0;
    else if (strobe.rstSet) periphRst <= 1'b1;
    else if (strobe.rstClr) periphRst <= 1'b0;
  end

  generate
    if (RUN_HIGH) begin : g_runHigh
      assign ctrlBit = running;
    end else begin : g_stopHigh
      assign ctrlBit = ~running;
    end
  endgenerate
endmodule

// File: rtl/periph_clk_gate.sv
`timescale 1ns/1ps
module periph_clk_gate
  import gate_seq_pkg::*;
#(
  parameter int          GATE_POS   = 1,
  parameter int          RST_POS    = 7,
  parameter int unsigned PRE_TICKS  = 100,
  parameter int unsigned POST_TICKS = 10000
) (
  input  logic clk,
  input  logic rstN,
  input  logic refTick,
  input  logic enReq,
  input  logic disReq,
  output logic ctrlBit,
  output logic periphRst,
  output logic busy,
  output logic clkOn,
  output logic gatedClk
);
  localparam bit HAS_RST  = (RST_POS >= 0);
  localparam bit RUN_HIGH = (GATE_POS == 14);

  seqStrobe_t strobe;
  logic       preDone, postDone, running;

  gate_seq_ctrl #(.HAS_RST(HAS_RST)) u_ctrl (
    .clk(clk), .rstN(rstN), .enReq(enReq), .disReq(disReq),
    .preDone(preDone), .postDone(postDone), .strobe(strobe), .busy(busy)
  );

  gate_seq_dp #(.PRE_TICKS(PRE_TICKS), .POST_TICKS(POST_TICKS), .RUN_HIGH(RUN_HIGH)) u_dp (
    .clk(clk), .rstN(rstN), .refTick(refTick), .strobe(strobe),
    .preDone(preDone), .postDone(postDone), .ctrlBit(ctrlBit),
    .periphRst(periphRst), .running(running)
  );

  gate_glitchfree_cell u_cell (.clk(clk), .en(running), .gclk(gatedClk));

  assign clkOn = running;
endmodule

// File: rtl/periph_clk_gate_chk.sv
`timescale 1ns/1ps
module periph_clk_gate_chk #(
  parameter int RST_POS = 7
) (
  input logic clk,
  input logic rstN,
  input logic enReq,
  input logic disReq,
  input logic periphRst,
  input logic busy,
  input logic clkOn
);
  localparam bit HAS_RST = (RST_POS >= 0);

  // R7: gates without reset never sequence
  p_no_seq_r7: assert property (@(posedge clk) disable iff (!rstN)
    !HAS_RST |-> (!busy && !periphRst));

  // R4: clock may start on a reset gate only with reset already held
  p_rst_leads_clk_r4: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_RST && $rose(clkOn)) |-> (periphRst && $past(periphRst)));

  // R6: reset is only held inside a sequence
  p_rst_in_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    periphRst |-> busy);

  // R6: release of reset ends the sequence
  p_release_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(periphRst) |-> !busy);

  // R8: idle disable leaves reset alone and stops the clock
  p_dis_stops_r8: assert property (@(posedge clk) disable iff (!rstN)
    (disReq && !enReq && !busy) |=> ($stable(periphRst) && !clkOn && !busy));

  // R9: the clock is never stopped out of a running sequence
  p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkOn) |-> !$past(busy));
endmodule

bind periph_clk_gate periph_clk_gate_chk #(.RST_POS(RST_POS)) u_chk (
  .clk(clk), .rstN(rstN), .enReq(enReq), .disReq(disReq),
  .periphRst(periphRst), .busy(busy), .clkOn(clkOn)
);

// File: tb/test_periph_clk_gate.sv
`timescale 1ns/1ps
module test_periph_clk_gate;
  localparam int PRE  = 3;
  localparam int POST = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b0, enReq = 1'b0, disReq = 1'b0;
  logic [2:0] ctrlV, rstV, busyV, onV, gclkV;

  always #4 clk = ~clk;

  // 0: gate with reset, 1: gate without reset, 2: inverted gate with reset
  periph_clk_gate #(.GATE_POS(1), .RST_POS(7), .PRE_TICKS(PRE), .POST_TICKS(POST)) i_periph_clk_gate (
    .clk(clk), .rstN(rstN), .refTick(refTick), .enReq(enReq), .disReq(disReq),
    .ctrlBit(ctrlV[0]), .periphRst(rstV[0]), .busy(busyV[0]), .clkOn(onV[0]), .gatedClk(gclkV[0]));
  periph_clk_gate #(.GATE_POS(5), .RST_POS(-1), .PRE_TICKS(PRE), .POST_TICKS(POST)) i_periph_clk_gate_noRst (
    .clk(clk), .rstN(rstN), .refTick(refTick), .enReq(enReq), .disReq(disReq),
    .ctrlBit(ctrlV[1]), .periphRst(rstV[1]), .busy(busyV[1]), .clkOn(onV[1]), .gatedClk(gclkV[1]));
  periph_clk_gate #(.GATE_POS(14), .RST_POS(14), .PRE_TICKS(PRE), .POST_TICKS(POST)) i_periph_clk_gate_inv (
    .clk(clk), .rstN(rstN), .refTick(refTick), .enReq(enReq), .disReq(disReq),
    .ctrlBit(ctrlV[2]), .periphRst(rstV[2]), .busy(busyV[2]), .clkOn(onV[2]), .gatedClk(gclkV[2]));

  int checks = 0, failures = 0;
  bit cmpOn = 1'b0, done = 1'b0;
  string curTag = "R1";

  // behavioural reference model
  bit hasRst [3] = '{1'b1, 1'b0, 1'b1};
  bit runHigh[3] = '{1'b0, 1'b0, 1'b1};
  int st[3], cnt[3];
  bit mOn[3], mRst[3], prevOn[3];

  always @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      prevOn[k] = mOn[k];
      if (!rstN) begin
        st[k] = 0; cnt[k] = 0; mOn[k] = 0; mRst[k] = 0;
      end else begin
        case (st[k])
          0: if (enReq) begin
               if (hasRst[k]) begin mRst[k] = 1; st[k] = 1; cnt[k] = 0; end
               else mOn[k] = 1;
             end else if (disReq) mOn[k] = 0;
          1: if (refTick) begin
               cnt[k]++;
               if (cnt[k] == PRE) begin mOn[k] = 1; st[k] = 2; cnt[k] = 0; end
             end
          default: if (refTick) begin
               cnt[k]++;
               if (cnt[k] == POST) begin mRst[k] = 0; st[k] = 0; cnt[k] = 0; end
             end
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string what, input int k, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s gate%0d act=%0d exp=%0d", curTag, what, k, act, exp);
    end
  endtask

  // registered outputs and low-phase gated clock, mid low phase
  always @(negedge clk) begin
    #2;
    if (cmpOn) begin
      for (int k = 0; k < 3; k++) begin
        bit expCtrl;
        expCtrl = runHigh[k] ? mOn[k] : !mOn[k];
        check(ctrlV[k] == expCtrl, "ctrlBit", k, ctrlV[k], expCtrl);
        check(rstV[k] == mRst[k], "periphRst", k, rstV[k], mRst[k]);
        check(busyV[k] == (st[k] != 0), "busy", k, busyV[k], st[k] != 0);
        check(onV[k] == mOn[k], "clkOn", k, onV[k], mOn[k]);
        check(gclkV[k] == 1'b0, "R11 gatedClk low phase", k, gclkV[k], 0);
      end
    end
  end

  // R11: high phase follows status from before the edge
  always @(posedge clk) begin
    #2;
    if (cmpOn) begin
      for (int k = 0; k < 3; k++)
        check(gclkV[k] == prevOn[k], "R11 gatedClk high phase", k, gclkV[k], prevOn[k]);
    end
  end

  task automatic step(input bit en, input bit dis, input bit tick);
    @(negedge clk);
    #1;
    enReq = en; disReq = dis; refTick = tick;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired in %s", curTag);
      finishRun();
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    // R1: reset values at the ports
    for (int k = 0; k < 3; k++) begin
      check(ctrlV[k] == (runHigh[k] ? 1'b0 : 1'b1), "R1 ctrlBit", k, ctrlV[k], runHigh[k] ? 0 : 1);
      check(rstV[k] == 1'b0 && busyV[k] == 1'b0, "R1 rst/busy", k, {rstV[k], busyV[k]}, 0);
      check(onV[k] == 1'b0, "R1 clkOn", k, onV[k], 0);
    end
    rstN = 1'b1;
    @(posedge clk);
    cmpOn = 1'b1;

    // R4 R5 R6 R7: full enable sequence, tick in the acceptance cycle
    curTag = "R4 R5 R6 R7";
    step(1, 0, 1);
    for (int i = 0; i < 30; i++) step(0, 0, i % 2 == 0);

    // R9: requests inside a running sequence
    curTag = "R9";
    step(1, 0, 0);
    step(0, 1, 1);
    step(1, 0, 0);
    step(0, 1, 1);
    for (int i = 0; i < 12; i++) step(0, 1, 1);
    step(0, 0, 0);

    // R8 R2 R3: idle disable
    curTag = "R8 R2 R3";
    step(0, 1, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1);

    // R10: both requests in one idle cycle
    curTag = "R10";
    step(1, 1, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 1);

    // R2 R3 R5 R6 R9: pseudo-random traffic
    curTag = "R2 R3 R5 R6 R9 random";
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] == 4'd1, lfsr[7:4] == 4'd2, lfsr[9] | lfsr[11]);
    end
    step(0, 0, 0);
    @(negedge clk); #3;
    done = 1'b1;
    finishRun();
  end
endmodule